// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits between a processor that reports its bus activity as a 3-bit status code and a system bus that needs discrete command strobes. It watches the status code on every rising clock edge. When the code moves away from the all-ones idle value, it opens a bus cycle. It issues a one-clock address-latch pulse, then drives exactly one command strobe from the second clock onward. The command is memory read, memory write, I/O read, I/O write or interrupt acknowledge. The strobe stays up until the status code is seen back at the idle value.

The code seen on the opening edge is latched and decides the command for the whole cycle. Code changes in the middle of a cycle have no effect. The block also drives a transceiver enable that follows the strobe. It drives a direction line that is high for the whole of a write cycle and low otherwise. A halt code runs a latch-only cycle with no strobe and sets a halted flag. While that flag is set, further halt codes are ignored until some other command code opens a cycle.

All outputs are active high. They come straight from registered state, so each one changes only just after a rising clock edge.

Top module: `bus_cmd_gen`

## Requirements
- R1: While rst_n is low, and after its release until a cycle opens, ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, den, dir_tx and halted are all 0.
- R2: A cycle opens on a rising edge where bus_status is not 3'b111 and the code sampled on the previous edge (or the reset value) was 3'b111. ale is then 1 for exactly the one clock that follows that edge.
- R3: The latched code selects the strobe as follows: 3'b000 int_ack, 3'b001 io_rd, 3'b010 io_wr, 3'b100 mem_rd (opcode fetch), 3'b101 mem_rd, 3'b110 mem_wr.
- R4: The strobe rises on the edge after the opening edge, provided bus_status is still not 3'b111 there. It stays high until the first edge that samples 3'b111, and it is 0 from that edge on.
- R5: At most one of mem_rd, mem_wr, io_rd, io_wr, int_ack is 1 in any clock.
- R6: A change of bus_status between two non-idle codes inside an open cycle neither changes the strobe nor opens a new cycle.
- R7: Code 3'b011 (halt) opens a cycle with its ale pulse but raises no strobe and no den. The halted output goes to 1 on the opening edge.
- R8: While halted is 1, a move from 3'b111 to 3'b011 opens no cycle and gives no ale. Any other non-idle code after 3'b111 opens a normal cycle and clears halted on its opening edge.
- R9: den is 1 exactly while a command strobe is 1. dir_tx is 1 from the ale clock to the end of a cycle whose code is 3'b010 or 3'b110, and 0 in all other clocks.
- R10: If bus_status is 3'b111 again on the edge right after the opening edge, the cycle closes with the ale pulse only and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_status | input | 3 | Processor status code, 3'b111 = idle |
| ale | output | 1 | Address-latch pulse, first clock of a cycle |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |
| den | output | 1 | Data transceiver enable |
| dir_tx | output | 1 | Transceiver direction, 1 = outbound (write) |
| halted | output | 1 | Processor has reported a halt |

## Verification
Take the rising edge where a non-idle code follows an idle sample. ale and halted are due in the clock right after that edge. The command strobe and den are due one edge later. The strobe drops in the clock after the first edge that samples 3'b111, and dir_tx already holds its final value in the ale clock. The bench drives bus_status only at falling edges and steps its own cycle model at each rising edge. It compares every output at the next falling edge, half a period after the register update and before the next input change. This keeps every comparison aligned with those one- and two-edge latencies.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   localparam int CMD_N    = 5;
   localparam int CMD_MRD  = 0;
   localparam int CMD_MWR  = 1;
   localparam int CMD_IORD = 2;
   localparam int CMD_IOWR = 3;
   localparam int CMD_INTA = 4;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LATCH = 2'd1,
      PH_CMD   = 2'd2
   } phase_e;

   typedef struct packed {
      logic [CMD_N-1:0] cmd;
      logic             halt;
      logic             write;
      logic             has_cmd;
   } decode_t;

endpackage

// File: rtl/bcg_status_decode.sv
module bcg_status_decode
   import bcg_pkg::*;
#(
   parameter int              CODE_W        = 3,
   parameter logic [CODE_W-1:0] CODE_INTA   = CODE_W'(0),
   parameter logic [CODE_W-1:0] CODE_IORD   = CODE_W'(1),
   parameter logic [CODE_W-1:0] CODE_IOWR   = CODE_W'(2),
   parameter logic [CODE_W-1:0] CODE_HALT   = CODE_W'(3),
   parameter logic [CODE_W-1:0] CODE_FETCH  = CODE_W'(4),
   parameter logic [CODE_W-1:0] CODE_MRD    = CODE_W'(5),
   parameter logic [CODE_W-1:0] CODE_MWR    = CODE_W'(6),
   parameter logic [CODE_W-1:0] CODE_IDLE   = CODE_W'(7),
   parameter bit                FETCH_AS_READ = 1'b1
) (
   input  logic [CODE_W-1:0] code_i,
   output decode_t           dec_o,
   output logic              idle_o
);

   logic fetch_rd;

   if (FETCH_AS_READ) begin : g_fetch_read
      assign fetch_rd = (code_i == CODE_FETCH);
   end else begin : g_fetch_silent
      assign fetch_rd = 1'b0;
   end

   always_comb begin
      dec_o                = '0;
      dec_o.cmd[CMD_INTA]  = (code_i == CODE_INTA);
      dec_o.cmd[CMD_IORD]  = (code_i == CODE_IORD);
      dec_o.cmd[CMD_IOWR]  = (code_i == CODE_IOWR);
      dec_o.cmd[CMD_MRD]   = (code_i == CODE_MRD) | fetch_rd;
      dec_o.cmd[CMD_MWR]   = (code_i == CODE_MWR);
      dec_o.halt           = (code_i == CODE_HALT);
      dec_o.write          = (code_i == CODE_IOWR) | (code_i == CODE_MWR);
      dec_o.has_cmd        = |dec_o.cmd;
   end

   assign idle_o = (code_i == CODE_IDLE);

endmodule

// File: rtl/bcg_sequencer.sv
module bcg_sequencer
   import bcg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    idle_i,
   input  decode_t live_i,
   output phase_e  phase_o,
   output decode_t lat_o,
   output logic    halted_o
);

   phase_e  phase_q;
   decode_t lat_q;
   logic    prev_idle_q;
   logic    halted_q;
   logic    open_cycle;

   assign open_cycle = prev_idle_q & ~idle_i & ~(halted_q & live_i.halt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         lat_q       <= '0;
         prev_idle_q <= 1'b1;
         halted_q    <= 1'b0;
      end else begin
         prev_idle_q <= idle_i;
         unique case (phase_q)
            PH_IDLE: begin
               if (open_cycle) begin
                  phase_q  <= PH_LATCH;
                  lat_q    <= live_i;
                  halted_q <= live_i.halt;
               end
            end
            PH_LATCH: phase_q <= idle_i ? PH_IDLE : PH_CMD;
            PH_CMD: begin
               if (idle_i) phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o  = phase_q;
   assign lat_o    = lat_q;
   assign halted_o = halted_q;

endmodule

// File: rtl/bcg_strobe_out.sv
module bcg_strobe_out
   import bcg_pkg::*;
(
   input  phase_e           phase_i,
   input  decode_t          lat_i,
   output logic             ale_o,
   output logic [CMD_N-1:0] cmd_o,
   output logic             den_o,
   output logic             dir_o
);

   logic in_cmd;

   assign in_cmd = (phase_i == PH_CMD);

   for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
      assign cmd_o[i] = in_cmd & lat_i.cmd[i];
   end

   assign ale_o = (phase_i == PH_LATCH);
   assign den_o = in_cmd & lat_i.has_cmd & ~lat_i.halt;
   assign dir_o = (phase_i != PH_IDLE) & lat_i.write;

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
   import bcg_pkg::*;
#(
   parameter int CODE_W        = 3,
   parameter bit FETCH_AS_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] bus_status,
   output logic              ale,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              int_ack,
   output logic              den,
   output logic              dir_tx,
   output logic              halted
);

   localparam logic [CODE_W-1:0] IDLE_CODE = '1;

   if (CODE_W < 3) begin : g_bad_width
      $error("bus_cmd_gen: CODE_W must be at least 3");
   end

   decode_t          live_dec;
   decode_t          lat_dec;
   logic             live_idle;
   phase_e           phase;
   logic [CMD_N-1:0] cmd;

   bcg_status_decode #(
      .CODE_W        (CODE_W),
      .CODE_IDLE     (IDLE_CODE),
      .FETCH_AS_READ (FETCH_AS_READ)
   ) u_decode (
      .code_i (bus_status),
      .dec_o  (live_dec),
      .idle_o (live_idle)
   );

   bcg_sequencer u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_i   (live_idle),
      .live_i   (live_dec),
      .phase_o  (phase),
      .lat_o    (lat_dec),
      .halted_o (halted)
   );

   bcg_strobe_out u_out (
      .phase_i (phase),
      .lat_i   (lat_dec),
      .ale_o   (ale),
      .cmd_o   (cmd),
      .den_o   (den),
      .dir_o   (dir_tx)
   );

   assign mem_rd  = cmd[CMD_MRD];
   assign mem_wr  = cmd[CMD_MWR];
   assign io_rd   = cmd[CMD_IORD];
   assign io_wr   = cmd[CMD_IOWR];
   assign int_ack = cmd[CMD_INTA];

endmodule

// File: rtl/bus_cmd_gen_checker.sv
module bus_cmd_gen_checker #(
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] bus_status,
   input logic              ale,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              io_rd,
   input logic              io_wr,
   input logic              int_ack,
   input logic              den,
   input logic              dir_tx,
   input logic              halted
);

   localparam logic [CODE_W-1:0] IDLE_CODE = '1;

   logic [4:0] cmds;
   assign cmds = {int_ack, io_wr, io_rd, mem_wr, mem_rd};

   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmds));

   assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   assert_ale_after_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> $past(bus_status) != IDLE_CODE);

   assert_strobe_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|cmds) |-> $past(ale));

   assert_strobe_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmds) && bus_status == IDLE_CODE) |=> !(|cmds));

   assert_strobe_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmds) && bus_status != IDLE_CODE) |=> $stable(cmds));

   assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (cmds == 5'b0 && !den));

   assert_den_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      den == (|cmds));

   assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || io_wr) |-> dir_tx);

   assert_dir_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || io_rd || int_ack) |-> !dir_tx);

endmodule

bind bus_cmd_gen bus_cmd_gen_checker #(.CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_status (bus_status),
   .ale        (ale),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .io_rd      (io_rd),
   .io_wr      (io_wr),
   .int_ack    (int_ack),
   .den        (den),
   .dir_tx     (dir_tx),
   .halted     (halted)
);

// File: tb/bus_cmd_gen_bench.sv
`timescale 1ns/1ps
module bus_cmd_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_status = 3'b111;
   logic       ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, den, dir_tx, halted;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string strobe_tag = "R4";

   // bench cycle model
   bit       m_prev_idle = 1'b1;
   int       m_phase = 0;      // 0 idle, 1 latch clock, 2 command clocks
   bit [2:0] m_code = 3'b000;
   bit       m_halted = 1'b0;

   always #2.5 clk = ~clk;

   bus_cmd_gen u_bus_cmd_gen (
      .clk(clk), .rst_n(rst_n), .bus_status(bus_status),
      .ale(ale), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
      .io_wr(io_wr), .int_ack(int_ack), .den(den), .dir_tx(dir_tx),
      .halted(halted)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev_idle = 1'b1; m_phase = 0; m_code = 3'b000; m_halted = 1'b0;
      end else begin
         bit idle_now;
         idle_now = (bus_status == 3'b111);
         case (m_phase)
            0: if (m_prev_idle && !idle_now && !(m_halted && bus_status == 3'b011)) begin
                  m_phase = 1; m_code = bus_status; m_halted = (bus_status == 3'b011);
               end
            1: m_phase = idle_now ? 0 : 2;
            default: if (idle_now) m_phase = 0;
         endcase
         m_prev_idle = idle_now;
      end
   end

   // strobe vector order {int_ack, io_wr, io_rd, mem_wr, mem_rd}
   function automatic logic [4:0] code_strobe(input bit [2:0] c);
      case (c)
         3'b000: return 5'b10000;
         3'b001: return 5'b00100;
         3'b010: return 5'b01000;
         3'b100, 3'b101: return 5'b00001;
         3'b110: return 5'b00010;
         default: return 5'b00000;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all();
      logic [4:0] e_cmd;
      e_cmd = (m_phase == 2) ? code_strobe(m_code) : 5'b0;
      check("R2", "ale", {4'b0, ale}, {4'b0, m_phase == 1});
      check(strobe_tag, "strobes", {int_ack, io_wr, io_rd, mem_wr, mem_rd}, e_cmd);
      check("R5", "one strobe", {4'b0, $countones({int_ack, io_wr, io_rd, mem_wr, mem_rd}) <= 1}, 5'b1);
      check("R9", "den", {4'b0, den}, {4'b0, |e_cmd});
      check("R9", "dir_tx", {4'b0, dir_tx},
            {4'b0, m_phase != 0 && (m_code == 3'b010 || m_code == 3'b110)});
      check(m_halted ? "R8" : "R7", "halted", {4'b0, halted}, {4'b0, m_halted});
   endtask

   task automatic put(input logic [2:0] v);
      @(negedge clk);
      check_all();
      bus_status = v;
   endtask

   task automatic run_cycle(input logic [2:0] c, input int len);
      put(3'b111);
      put(c);
      for (int i = 1; i < len; i++) put(c);
      put(3'b111);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      check("R1", "reset outputs",
            {ale, mem_rd | mem_wr | io_rd | io_wr | int_ack, den, dir_tx, halted}, 5'b0);
      rst_n = 1'b1;
      put(3'b111); put(3'b111);
      check("R1", "after release", {ale, den, dir_tx, halted, mem_rd}, 5'b0);

      // R3: every command code in turn
      strobe_tag = "R3";
      run_cycle(3'b000, 3); run_cycle(3'b001, 3); run_cycle(3'b010, 4);
      run_cycle(3'b100, 3); run_cycle(3'b101, 2); run_cycle(3'b110, 5);

      // R6: code changes inside an open cycle
      strobe_tag = "R6";
      put(3'b111); put(3'b001); put(3'b110); put(3'b000); put(3'b101); put(3'b111);
      put(3'b010); put(3'b010); put(3'b100); put(3'b111);

      // R10: idle right after the opening edge
      strobe_tag = "R10";
      put(3'b111); put(3'b101); put(3'b111); put(3'b111);

      // R7 / R8: halt, repeated halt ignored, then resume
      strobe_tag = "R7";
      run_cycle(3'b011, 3);
      strobe_tag = "R8";
      run_cycle(3'b011, 2);
      put(3'b011); put(3'b101); put(3'b111);
      run_cycle(3'b010, 3);

      // random traffic
      strobe_tag = "R4";
      for (int n = 0; n < 500; n++) begin
         int gap, len;
         gap = $urandom_range(0, 3);
         len = $urandom_range(1, 5);
         for (int g = 0; g < gap; g++) put(3'b111);
         put(3'($urandom_range(0, 6)));
         for (int k = 1; k < len; k++)
            put(($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 6)) : bus_status);
         put(3'b111);
      end
      put(3'b111); put(3'b111);
      finish_run();
   end

endmodule